// File: doc/BRIEF.md
# Big-Endian Byte-Lane Load/Store Port

This block sits between a processor's load/store stage and a data memory that is 32 bits wide and addressed by word. For each request it adds a signed 16-bit displacement to a base register value to get a byte address. From that address it derives the word index sent to memory and a 4-bit lane write mask. On stores it places the operand on the byte lanes that the access covers.

Lanes follow big-endian order: the byte at the lowest address inside a word occupies bits 31:24. Sub-word values always travel through the low end of the register. A store of a byte or halfword takes its value from the register's bottom bits. A load of a byte or halfword returns the value right-justified and sign-extended to 32 bits.

Word and halfword requests whose address breaks alignment raise a flag. Such a request produces no memory enable, no write lanes and no load result. The memory array is outside the block. It is read synchronously, so a load result appears one clock after its request.

Top module: `be_mem_port`

## Requirements
- R1: `eff_addr` equals `req_base` plus `req_offset` sign-extended from 16 bits, in the same cycle as the request.
- R2: `mem_addr` equals `eff_addr` shifted right by two, so consecutive words are four byte addresses apart.
- R3: A word store (`req_size` = 2'b10) at an address whose two low bits are 00 sets all four bits of `mem_we` and drives `req_wdata` unchanged on `mem_wdata`.
- R4: A byte store (`req_size` = 2'b00) sets exactly one `mem_we` bit, bit (3 − byte offset), so offset 0 maps to bit 3. It places `req_wdata[7:0]` on the lane with bits 8·(3−offset)+7 to 8·(3−offset).
- R5: A halfword store (`req_size` = 2'b01) at offset 0 sets `mem_we` = 4'b1100 and places `req_wdata[15:0]` on bits 31:16. At offset 2 it sets `mem_we` = 4'b0011 and places the same value on bits 15:0.
- R6: A word request whose address has nonzero low two bits, or a halfword request with address bit 0 set, raises `misalign`. Such a request keeps `mem_en` low, keeps `mem_we` at zero, leaves memory unchanged and yields no `load_valid`. A byte request never raises `misalign`.
- R7: An aligned load drives `mem_en` high with `mem_we` zero, and `load_valid` rises in the next cycle only.
- R8: A byte load returns the byte at offset k from word bits 31−8k down to 24−8k, sign-extended from bit 7.
- R9: A halfword load returns word bits 31:16 at offset 0 and bits 15:0 at offset 2, sign-extended from bit 15.
- R10: A word load returns the addressed memory word unchanged.
- R11: When `req_valid` is low, `mem_en`, `mem_we` and `misalign` are all zero. `load_valid` is zero during reset.
- R12: Size code 2'b11 behaves exactly like a word access for alignment, strobes, store data and load data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 word |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Two's-complement displacement |
| req_wdata | input | 32 | Store operand register |
| eff_addr | output | 32 | Effective byte address |
| misalign | output | 1 | Alignment violation on this request |
| mem_en | output | 1 | Memory access enable |
| mem_addr | output | 30 | Word index to memory |
| mem_we | output | 4 | Lane write mask, bit 3 = byte offset 0 |
| mem_wdata | output | 32 | Lane-positioned store data |
| mem_rdata | input | 32 | Read word, one cycle after `mem_en` |
| load_valid | output | 1 | Load result present |
| load_data | output | 32 | Right-justified, extended load result |

## Verification
The address, word index, alignment flag, enable, lane mask and lane data are combinational, so they are due in the cycle of the request. The bench drives each request at a falling edge and samples these outputs 2 ns later. Load data passes through the synchronous memory read and a registered size and offset, so it is due one cycle after the request. The bench holds that expected result and compares it when it samples the following request or idle cycle. Expected values come from a byte-wide shadow memory that the bench updates behaviourally, address by address.

// File: rtl/be_lsu_pkg.sv
package be_lsu_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_WIDE = 2'b11
   } acc_size_e;

   // number of bytes covered by an access of the given size
   function automatic int unsigned size_bytes(acc_size_e s);
      case (s)
         SZ_BYTE: return 1;
         SZ_HALF: return 2;
         default: return 4;
      endcase
   endfunction

endpackage

// File: rtl/be_addr_gen.sv
module be_addr_gen
   import be_lsu_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int OFFS_W    = 16,
   parameter int LANE_BITS = 2,
   localparam int WADDR_W  = ADDR_W - LANE_BITS
) (
   input  logic                  valid,
   input  acc_size_e             size,
   input  logic [ADDR_W-1:0]     base,
   input  logic [OFFS_W-1:0]     offset,
   output logic [ADDR_W-1:0]     eff_addr,
   output logic [WADDR_W-1:0]    word_addr,
   output logic [LANE_BITS-1:0]  lane_ofs,
   output logic                  misalign
);

   if (ADDR_W <= OFFS_W) begin : g_bad_width
      $error("be_addr_gen: ADDR_W must exceed OFFS_W");
   end

   logic [ADDR_W-1:0] off_ext;
   logic              bad_align;

   assign off_ext   = {{(ADDR_W-OFFS_W){offset[OFFS_W-1]}}, offset};
   assign eff_addr  = base + off_ext;
   assign word_addr = eff_addr[ADDR_W-1:LANE_BITS];
   assign lane_ofs  = eff_addr[LANE_BITS-1:0];

   always_comb begin
      case (size)
         SZ_BYTE: bad_align = 1'b0;
         SZ_HALF: bad_align = lane_ofs[0];
         default: bad_align = |lane_ofs;
      endcase
   end

   assign misalign = valid & bad_align;

endmodule

// File: rtl/be_store_lanes.sv
module be_store_lanes
   import be_lsu_pkg::*;
#(
   parameter int DATA_W    = 32,
   localparam int LANES     = DATA_W / 8,
   localparam int LANE_BITS = $clog2(LANES)
) (
   input  logic                  en,
   input  acc_size_e             size,
   input  logic [LANE_BITS-1:0]  lane_ofs,
   input  logic [DATA_W-1:0]     store_data,
   output logic [LANES-1:0]      we,
   output logic [DATA_W-1:0]     wdata
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      // big-endian: lane i holds the byte at offset LANES-1-i
      localparam logic [LANE_BITS-1:0] POS = LANE_BITS'(LANES - 1 - i);
      logic       hit;
      logic [7:0] lane_byte;

      always_comb begin
         case (size)
            SZ_BYTE: begin
               hit       = (lane_ofs == POS);
               lane_byte = store_data[7:0];
            end
            SZ_HALF: begin
               hit       = (lane_ofs[LANE_BITS-1] == POS[LANE_BITS-1]);
               lane_byte = POS[0] ? store_data[7:0] : store_data[15:8];
            end
            default: begin
               hit       = 1'b1;
               lane_byte = store_data[8*i +: 8];
            end
         endcase
      end

      assign we[i]           = en & hit;
      assign wdata[8*i +: 8] = lane_byte;
   end

endmodule

// File: rtl/be_load_align.sv
module be_load_align
   import be_lsu_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter bit SIGN_EXT  = 1'b1,
   localparam int LANE_BITS = $clog2(DATA_W / 8)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  capture,
   input  acc_size_e             size,
   input  logic [LANE_BITS-1:0]  lane_ofs,
   input  logic [DATA_W-1:0]     rdata,
   output logic                  load_valid,
   output logic [DATA_W-1:0]     load_data
);

   logic                  valid_q;
   acc_size_e             size_q;
   logic [LANE_BITS-1:0]  ofs_q;
   logic [7:0]            sel_b;
   logic [15:0]           sel_h;
   logic [DATA_W-9:0]     fill_b;
   logic [DATA_W-17:0]    fill_h;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         size_q  <= SZ_WORD;
         ofs_q   <= '0;
      end else begin
         valid_q <= capture;
         if (capture) begin
            size_q <= size;
            ofs_q  <= lane_ofs;
         end
      end
   end

   always_comb begin
      case (ofs_q)
         2'd0:    sel_b = rdata[31:24];
         2'd1:    sel_b = rdata[23:16];
         2'd2:    sel_b = rdata[15:8];
         default: sel_b = rdata[7:0];
      endcase
      sel_h = ofs_q[1] ? rdata[15:0] : rdata[31:16];
   end

   if (SIGN_EXT) begin : g_sext
      assign fill_b = {(DATA_W-8){sel_b[7]}};
      assign fill_h = {(DATA_W-16){sel_h[15]}};
   end else begin : g_zext
      assign fill_b = '0;
      assign fill_h = '0;
   end

   always_comb begin
      case (size_q)
         SZ_BYTE: load_data = {fill_b, sel_b};
         SZ_HALF: load_data = {fill_h, sel_h};
         default: load_data = rdata;
      endcase
   end

   assign load_valid = valid_q;

   // R7: a result appears only in the cycle after an accepted load
   assert_load_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load_valid |-> $past(capture));

   // R7: every accepted load yields a result one cycle later
   assert_load_due_R7: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> load_valid);

endmodule

// File: rtl/be_mem_port.sv
module be_mem_port
   import be_lsu_pkg::*;
#(
   parameter int ADDR_W         = 32,
   parameter int OFFS_W         = 16,
   parameter int DATA_W         = 32,
   parameter bit SIGN_EXT_LOADS = 1'b1,
   localparam int LANES          = DATA_W / 8,
   localparam int LANE_BITS      = $clog2(LANES),
   localparam int WADDR_W        = ADDR_W - LANE_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_store,
   input  logic [1:0]          req_size,
   input  logic [ADDR_W-1:0]   req_base,
   input  logic [OFFS_W-1:0]   req_offset,
   input  logic [DATA_W-1:0]   req_wdata,
   output logic [ADDR_W-1:0]   eff_addr,
   output logic                misalign,
   output logic                mem_en,
   output logic [WADDR_W-1:0]  mem_addr,
   output logic [LANES-1:0]    mem_we,
   output logic [DATA_W-1:0]   mem_wdata,
   input  logic [DATA_W-1:0]   mem_rdata,
   output logic                load_valid,
   output logic [DATA_W-1:0]   load_data
);

   if (DATA_W != 32) begin : g_bad_data
      $error("be_mem_port: DATA_W must be 32");
   end

   acc_size_e              size_e;
   logic [LANE_BITS-1:0]   lane_ofs;
   logic                   access_ok;
   logic                   store_en;
   logic                   load_take;

   assign size_e = acc_size_e'(req_size);

   be_addr_gen #(
      .ADDR_W    (ADDR_W),
      .OFFS_W    (OFFS_W),
      .LANE_BITS (LANE_BITS)
   ) u_addr (
      .valid     (req_valid),
      .size      (size_e),
      .base      (req_base),
      .offset    (req_offset),
      .eff_addr  (eff_addr),
      .word_addr (mem_addr),
      .lane_ofs  (lane_ofs),
      .misalign  (misalign)
   );

   assign access_ok = req_valid & ~misalign;
   assign mem_en    = access_ok;
   assign store_en  = access_ok & req_store;
   assign load_take = access_ok & ~req_store;

   be_store_lanes #(
      .DATA_W     (DATA_W)
   ) u_store (
      .en         (store_en),
      .size       (size_e),
      .lane_ofs   (lane_ofs),
      .store_data (req_wdata),
      .we         (mem_we),
      .wdata      (mem_wdata)
   );

   be_load_align #(
      .DATA_W     (DATA_W),
      .SIGN_EXT   (SIGN_EXT_LOADS)
   ) u_load (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture    (load_take),
      .size       (size_e),
      .lane_ofs   (lane_ofs),
      .rdata      (mem_rdata),
      .load_valid (load_valid),
      .load_data  (load_data)
   );

   // R11: nothing reaches memory without a request
   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!mem_en && mem_we == '0 && !misalign));

   // R6: a misaligned request never writes or enables memory
   assert_misalign_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |-> (!mem_en && mem_we == '0));

   // R6: misaligned requests never produce a load result
   assert_misalign_no_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |=> !load_valid);

   // R4: a byte store touches exactly one lane
   assert_byte_one_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_store && size_e == SZ_BYTE) |-> $countones(mem_we) == 1);

   // R5: a halfword store touches exactly two lanes when aligned
   assert_half_two_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_store && size_e == SZ_HALF && !misalign) |-> $countones(mem_we) == 2);

   // R3 and R12: an aligned full-width store writes every lane
   assert_word_all_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_store && req_size[1] && !misalign) |-> mem_we == '1);

   // R7: loads never write
   assert_load_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_store) |-> mem_we == '0);

endmodule

// File: tb/sim_be_mem_port.sv
`timescale 1ns/1ps
module sim_be_mem_port;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_store;
   logic [1:0]  req_size;
   logic [31:0] req_base;
   logic [15:0] req_offset;
   logic [31:0] req_wdata;
   logic [31:0] eff_addr;
   logic        misalign, mem_en;
   logic [29:0] mem_addr;
   logic [3:0]  mem_we;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata;
   logic        load_valid;
   logic [31:0] load_data;

   int errors = 0;
   int checks = 0;

   logic [31:0] mem [0:15];
   logic [7:0]  shadow [0:63];

   logic        pend;
   logic [31:0] pend_data;
   string       pend_tag;

   always #10 clk = ~clk;

   be_mem_port u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_store  (req_store),
      .req_size   (req_size),
      .req_base   (req_base),
      .req_offset (req_offset),
      .req_wdata  (req_wdata),
      .eff_addr   (eff_addr),
      .misalign   (misalign),
      .mem_en     (mem_en),
      .mem_addr   (mem_addr),
      .mem_we     (mem_we),
      .mem_wdata  (mem_wdata),
      .mem_rdata  (mem_rdata),
      .load_valid (load_valid),
      .load_data  (load_data)
   );

   // synchronous memory model, word wide
   always @(posedge clk) begin
      if (mem_en) begin
         for (int l = 0; l < 4; l++)
            if (mem_we[l]) mem[mem_addr[3:0]][8*l +: 8] <= mem_wdata[8*l +: 8];
         if (mem_we == 4'b0) mem_rdata <= mem[mem_addr[3:0]];
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_pending();
      if (pend) begin
         chk({pend_tag, " load_valid"}, {31'b0, load_valid}, 32'd1);
         chk({pend_tag, " load_data"}, load_data, pend_data);
      end else begin
         chk("R7 no load_valid", {31'b0, load_valid}, 32'd0);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0;
      #2;
      check_pending();
      pend = 1'b0;
      chk("R11 mem_en idle", {31'b0, mem_en}, 32'd0);
      chk("R11 mem_we idle", {28'b0, mem_we}, 32'd0);
      chk("R11 misalign idle", {31'b0, misalign}, 32'd0);
   endtask

   task automatic req(input logic st, input logic [1:0] sz, input logic [31:0] b,
                      input logic [15:0] o, input logic [31:0] d);
      logic [31:0] ea;
      logic [31:0] v;
      logic [3:0]  we_exp;
      logic        mis;
      int          n;
      int          lane;
      string       tag;
      @(negedge clk);
      req_valid  = 1'b1;
      req_store  = st;
      req_size   = sz;
      req_base   = b;
      req_offset = o;
      req_wdata  = d;
      #2;
      check_pending();
      ea  = b + {{16{o[15]}}, o};
      n   = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
      mis = (n == 2 && ea[0]) || (n == 4 && ea[1:0] != 2'b00);
      if (mis) tag = "R6";
      else if (sz == 2'b11) tag = "R12";
      else if (n == 1) tag = st ? "R4" : "R8";
      else if (n == 2) tag = st ? "R5" : "R9";
      else tag = st ? "R3" : "R10";
      chk("R1 eff_addr", eff_addr, ea);
      chk("R2 mem_addr", {2'b0, mem_addr}, {2'b0, ea[31:2]});
      chk({tag, " misalign"}, {31'b0, misalign}, {31'b0, mis});
      chk({tag, " mem_en"}, {31'b0, mem_en}, {31'b0, !mis});
      we_exp = 4'b0;
      if (st && !mis)
         for (int j = 0; j < n; j++) we_exp[3 - int'((ea + j) & 32'd3)] = 1'b1;
      chk(st ? {tag, " mem_we"} : "R7 mem_we", {28'b0, mem_we}, {28'b0, we_exp});
      if (st && !mis) begin
         for (int j = 0; j < n; j++) begin
            lane = 3 - int'((ea + j) & 32'd3);
            chk({tag, " lane data"}, {24'b0, mem_wdata[8*lane +: 8]}, {24'b0, d[8*(n-1-j) +: 8]});
            shadow[int'((ea + j) & 32'd63)] = d[8*(n-1-j) +: 8];
         end
      end
      pend = !st && !mis;
      if (pend) begin
         v = 32'b0;
         for (int j = 0; j < n; j++) v = {v[23:0], shadow[int'((ea + j) & 32'd63)]};
         if (n == 1) v = {{24{v[7]}}, v[7:0]};
         if (n == 2) v = {{16{v[15]}}, v[15:0]};
         pend_data = v;
         pend_tag  = (sz == 2'b11) ? "R12" : tag;
      end
   endtask

   localparam logic [31:0] B = 32'h2000_0000;

   initial begin
      #(20 * 100000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) shadow[i] = 8'((i * 37 + 11) & 255);
      for (int w = 0; w < 16; w++)
         mem[w] = {shadow[4*w], shadow[4*w+1], shadow[4*w+2], shadow[4*w+3]};
      mem_rdata  = 32'b0;
      pend       = 1'b0;
      pend_data  = 32'b0;
      pend_tag   = "";
      rst_n      = 1'b0;
      req_valid  = 1'b0;
      req_store  = 1'b0;
      req_size   = 2'b00;
      req_base   = 32'b0;
      req_offset = 16'b0;
      req_wdata  = 32'b0;
      repeat (3) @(negedge clk);
      chk("R11 reset load_valid", {31'b0, load_valid}, 32'd0);
      rst_n = 1'b1;
      idle();
      // word loads (R10)
      req(1'b0, 2'b10, B, 16'd0, 32'd0);
      req(1'b0, 2'b10, B, 16'd4, 32'd0);
      // byte loads at every offset (R8)
      for (int a = 8; a < 16; a++) req(1'b0, 2'b00, B, 16'(a), 32'd0);
      // halfword loads (R9)
      req(1'b0, 2'b01, B, 16'd16, 32'd0);
      req(1'b0, 2'b01, B, 16'd18, 32'd0);
      req(1'b0, 2'b10, B, 16'd20, 32'd0);
      // word store and read back (R3)
      req(1'b1, 2'b10, B, 16'd24, 32'h8123_45A6);
      req(1'b0, 2'b10, B, 16'd24, 32'd0);
      // byte stores at every offset, then reads (R4, R8)
      for (int k = 0; k < 4; k++)
         req(1'b1, 2'b00, B, 16'(28 + k), 32'hFFFF_FF00 | 32'(8'h80 + k * 8'h11));
      req(1'b0, 2'b10, B, 16'd28, 32'd0);
      for (int k = 0; k < 4; k++) req(1'b0, 2'b00, B, 16'(28 + k), 32'd0);
      // halfword stores (R5, R9)
      req(1'b1, 2'b01, B, 16'd32, 32'h1234_ABCD);
      req(1'b1, 2'b01, B, 16'd34, 32'h5678_7E01);
      req(1'b0, 2'b10, B, 16'd32, 32'd0);
      req(1'b0, 2'b01, B, 16'd32, 32'd0);
      req(1'b0, 2'b01, B, 16'd34, 32'd0);
      // misaligned requests (R6)
      for (int k = 1; k < 4; k++) req(1'b0, 2'b10, B, 16'(40 + k), 32'd0);
      req(1'b1, 2'b10, B, 16'd41, 32'hDEAD_BEEF);
      req(1'b1, 2'b01, B, 16'd45, 32'hCAFE_F00D);
      req(1'b1, 2'b01, B, 16'd47, 32'h0BAD_0BAD);
      req(1'b0, 2'b01, B, 16'd43, 32'd0);
      req(1'b1, 2'b00, B, 16'd41, 32'h0000_0055);
      req(1'b0, 2'b10, B, 16'd40, 32'd0);
      req(1'b0, 2'b10, B, 16'd44, 32'd0);
      // size code 11 (R12)
      req(1'b1, 2'b11, B, 16'd48, 32'h0F1E_2D3C);
      req(1'b0, 2'b11, B, 16'd48, 32'd0);
      req(1'b0, 2'b11, B, 16'd50, 32'd0);
      req(1'b1, 2'b11, B, 16'd49, 32'h7777_7777);
      // negative and large positive displacements (R1)
      req(1'b0, 2'b10, B + 32'h100, 16'hFF40, 32'd0);
      req(1'b1, 2'b00, B + 32'h100, 16'hFF47, 32'h0000_00C3);
      req(1'b0, 2'b00, B + 32'h100, 16'hFF47, 32'd0);
      req(1'b0, 2'b10, B - 32'h7FFC + 32'd52, 16'h7FFC, 32'd0);
      idle();
      idle();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule